// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block holds the pending state of the 32 private interrupts of one processor. Interrupts 0 to 15 are software-generated. Interrupts 16 to 31 come from peripheral level lines. The block samples each peripheral line once per clock and compares it with the previous sample. A rising line that is configured as edge-triggered sets a sticky pending latch. A line configured as level-triggered is instead merged live into the pending view, so the interrupt reads as pending only while the line stays high.

A software-generated request arrives as a single transfer carrying the interrupt number, the requested group and a non-secure flag. The block first works out the target interrupt's group from its group bit and its modifier bit. It then checks the requested group against that target group. When security is enabled, a non-secure request must also pass a per-interrupt access level. Only a request that passes both checks sets the latch.

The register file drives set-pending and clear-pending strobes, one per interrupt. The block produces two outputs: the effective pending vector, and a registered vector that marks each interrupt that is pending, enabled and not active.

Top module: `prv_irq_pend`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pending latch is clear, both output vectors are zero and no peripheral line is seen as high.
- R2: A peripheral line for interrupt n+16 that is sampled low on one clock and high on the next sets latch n+16 at that second clock, if edge bit n+16 is 1.
- R3: `pend_eff` equals the latch vector ORed with (sampled line level AND NOT edge bit). Lines 16..31 are sampled one clock late, and bits 0..15 have no line. A line whose edge bit is 0 never sets the latch, so its pending bit drops on the clock after the line falls.
- R4: A `set_pend` bit sets its latch at the next clock. A `clr_pend` bit clears its latch at the next clock.
- R5: A clear strobe and a new event on the same interrupt in the same cycle leave the latch set. A new event is a set strobe, an edge rise or an accepted request.
- R6: The target group uses this encoding: 0 is Group 0, 1 is secure Group 1, 2 is non-secure Group 1. The target is group 2 when its group bit is 1. It is group 1 when its group bit is 0, its modifier bit is 1 and `sec_dis` is 0. Otherwise it is group 0.
- R7: A request for group 1 whose target is group 0 is treated as a Group 0 request.
- R8: After that substitution, a request whose group differs from the target's group is dropped. A request with the unused group code 3 is always dropped.
- R9: When `sgi_ns` is 1 and `sec_dis` is 0, the check uses access field bits [2n+1:2n] of `cfg_nsacc` for request n. A group 0 target needs a field value of at least 1 and a group 1 target needs at least 2; otherwise the request is dropped. A group 2 target needs no minimum.
- R10: `pend_fire` is registered. At each clock it loads `pend_eff & irq_en & ~irq_act` as seen just before that clock.
- R11: `sgi_ready` is always 1, so every cycle with `sgi_valid` high is one complete request. An accepted request sets latch `sgi_id` at that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppi_line | input | 16 | Peripheral lines, bit k is interrupt k+16 |
| sgi_valid | input | 1 | Software-generated request valid |
| sgi_ready | output | 1 | Request accepted into the filter (always 1) |
| sgi_id | input | 4 | Target interrupt number 0..15 |
| sgi_grp | input | 2 | Requested group (encoding of R6) |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| cfg_edge | input | 32 | 1 = edge-triggered, 0 = level |
| cfg_grp | input | 32 | Group bit per interrupt |
| cfg_grpmod | input | 32 | Group modifier bit per interrupt |
| cfg_nsacc | input | 32 | Two-bit non-secure access level per request number |
| cfg_sec_dis | input | 1 | Security disabled |
| set_pend | input | 32 | Set-pending strobes |
| clr_pend | input | 32 | Clear-pending strobes |
| irq_en | input | 32 | Enable vector |
| irq_act | input | 32 | Active vector |
| pend_eff | output | 32 | Effective pending vector |
| pend_fire | output | 32 | Registered pending, enabled and not active |

## Verification
The assertions assume that every input is held low during reset. They also assume that `sgi_id` never exceeds 15, which a 4-bit field already guarantees.

The bench drives all inputs at the falling edge and keeps them at zero throughout reset. In the random phase, the strobes and request valid are sparse, so that latches survive long enough to be seen. That phase also uses every group code, including the unused value 3. A directed phase covers each group and access-level combination before the random phase starts.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;
  localparam int unsigned N_SGI_DEF = 16;
  localparam int unsigned N_PPI_DEF = 16;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2
  } grp_e;

  // Target group from group bit, modifier bit and security-disable.
  function automatic logic [1:0] target_grp(input logic gbit, input logic mbit,
                                            input logic sec_dis);
    if (gbit) return GRP_G1NS;
    if (mbit && !sec_dis) return GRP_G1S;
    return GRP_G0;
  endfunction
endpackage

// File: rtl/prv_line_sampler.sv
module prv_line_sampler #(
  parameter int unsigned N_PPI = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PPI-1:0] line_i,
  output logic [N_PPI-1:0] lvl_q,
  output logic [N_PPI-1:0] rise_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= line_i;
  end

  // A rise is a change from the held sample to a high input.
  assign rise_o = line_i & ~lvl_q;
endmodule

// File: rtl/prv_sgi_filter.sv
module prv_sgi_filter
  import prv_irq_pkg::*;
#(
  parameter int unsigned N_SGI = 16,
  localparam int unsigned IDW  = (N_SGI > 1) ? $clog2(N_SGI) : 1
) (
  input  logic               req_valid,
  input  logic [IDW-1:0]     req_id,
  input  logic [1:0]         req_grp,
  input  logic               req_ns,
  input  logic [N_SGI-1:0]   cfg_grp,
  input  logic [N_SGI-1:0]   cfg_mod,
  input  logic [2*N_SGI-1:0] cfg_nsacc,
  input  logic               sec_dis,
  output logic [N_SGI-1:0]   hit_o
);
  for (genvar k = 0; k < N_SGI; k++) begin : g_sgi
    logic [1:0] tgt;
    logic [1:0] eff_req;
    logic [1:0] acc;
    logic       grp_ok;
    logic       acc_ok;

    always_comb begin
      tgt     = target_grp(cfg_grp[k], cfg_mod[k], sec_dis);
      acc     = cfg_nsacc[2*k +: 2];
      eff_req = ((req_grp == GRP_G1S) && (tgt == GRP_G0)) ? GRP_G0 : req_grp;
      grp_ok  = (eff_req == tgt);
      acc_ok  = 1'b1;
      if (req_ns && !sec_dis) begin
        if (tgt == GRP_G0)       acc_ok = (acc >= 2'd1);
        else if (tgt == GRP_G1S) acc_ok = (acc >= 2'd2);
      end
      hit_o[k] = req_valid && (req_id == IDW'(k)) && grp_ok && acc_ok;
    end
  end
endmodule

// File: rtl/prv_pend_bank.sv
module prv_pend_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] latch_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         latch_q[i] <= 1'b0;
      else if (set_ev[i]) latch_q[i] <= 1'b1;   // new event beats clear
      else if (clr_ev[i]) latch_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/prv_irq_pend.sv
module prv_irq_pend
  import prv_irq_pkg::*;
#(
  parameter int unsigned N_SGI = N_SGI_DEF,
  parameter int unsigned N_PPI = N_PPI_DEF,
  localparam int unsigned N    = N_SGI + N_PPI,
  localparam int unsigned IDW  = (N_SGI > 1) ? $clog2(N_SGI) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PPI-1:0]   ppi_line,
  input  logic               sgi_valid,
  output logic               sgi_ready,
  input  logic [IDW-1:0]     sgi_id,
  input  logic [1:0]         sgi_grp,
  input  logic               sgi_ns,
  input  logic [N-1:0]       cfg_edge,
  input  logic [N-1:0]       cfg_grp,
  input  logic [N-1:0]       cfg_grpmod,
  input  logic [2*N_SGI-1:0] cfg_nsacc,
  input  logic               cfg_sec_dis,
  input  logic [N-1:0]       set_pend,
  input  logic [N-1:0]       clr_pend,
  input  logic [N-1:0]       irq_en,
  input  logic [N-1:0]       irq_act,
  output logic [N-1:0]       pend_eff,
  output logic [N-1:0]       pend_fire
);
  logic [N_PPI-1:0] lvl_q;
  logic [N_PPI-1:0] ppi_rise;
  logic [N_SGI-1:0] sgi_hit;
  logic [N-1:0]     lvl_full;
  logic [N-1:0]     rise_full;
  logic [N-1:0]     set_ev;
  logic [N-1:0]     pend_latch;

  assign sgi_ready = 1'b1;

  prv_line_sampler #(.N_PPI(N_PPI)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (ppi_line),
    .lvl_q  (lvl_q),
    .rise_o (ppi_rise)
  );

  prv_sgi_filter #(.N_SGI(N_SGI)) u_flt (
    .req_valid (sgi_valid),
    .req_id    (sgi_id),
    .req_grp   (sgi_grp),
    .req_ns    (sgi_ns),
    .cfg_grp   (cfg_grp[N_SGI-1:0]),
    .cfg_mod   (cfg_grpmod[N_SGI-1:0]),
    .cfg_nsacc (cfg_nsacc),
    .sec_dis   (cfg_sec_dis),
    .hit_o     (sgi_hit)
  );

  assign lvl_full  = {lvl_q, {N_SGI{1'b0}}};
  assign rise_full = {ppi_rise & cfg_edge[N-1:N_SGI], {N_SGI{1'b0}}};
  assign set_ev    = set_pend | rise_full | {{N_PPI{1'b0}}, sgi_hit};

  prv_pend_bank #(.N(N)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr_ev  (clr_pend),
    .latch_q (pend_latch)
  );

  assign pend_eff = pend_latch | (lvl_full & ~cfg_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_fire <= '0;
    else        pend_fire <= pend_eff & irq_en & ~irq_act;
  end
endmodule

// File: rtl/prv_irq_pend_chk.sv
module prv_irq_pend_chk #(
  parameter int unsigned N_SGI = 16,
  parameter int unsigned N_PPI = 16,
  localparam int unsigned N    = N_SGI + N_PPI,
  localparam int unsigned IDW  = (N_SGI > 1) ? $clog2(N_SGI) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sgi_valid,
  input logic               sgi_ns,
  input logic [IDW-1:0]     sgi_id,
  input logic [N-1:0]       cfg_grp,
  input logic [N-1:0]       cfg_grpmod,
  input logic [2*N_SGI-1:0] cfg_nsacc,
  input logic               cfg_sec_dis,
  input logic [N_SGI-1:0]   sgi_hit,
  input logic [N-1:0]       set_ev,
  input logic [N-1:0]       pend_latch,
  input logic [N-1:0]       pend_eff,
  input logic [N-1:0]       pend_fire
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R11: at most one request accepted, and only with valid
  p_one_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sgi_hit) && ((|sgi_hit) -> sgi_valid));

  // R5: an event in the previous cycle leaves the latch set
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((~pend_latch & $past(set_ev)) == '0));

  // R4: a latch bit only rises after an event
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_latch & ~$past(pend_latch) & ~$past(set_ev)) == '0));

  // R10: a firing bit was pending one cycle earlier
  p_fire_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_fire & ~$past(pend_eff)) == '0));

  // R9: non-secure request to a Group 0 target needs access level >= 1
  p_ns_g0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sgi_hit) && sgi_ns && !cfg_sec_dis && !cfg_grp[sgi_id] && !cfg_grpmod[sgi_id])
      |-> (cfg_nsacc[2*sgi_id +: 2] != 2'd0));
endmodule

bind prv_irq_pend prv_irq_pend_chk #(.N_SGI(N_SGI), .N_PPI(N_PPI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sgi_valid   (sgi_valid),
  .sgi_ns      (sgi_ns),
  .sgi_id      (sgi_id),
  .cfg_grp     (cfg_grp),
  .cfg_grpmod  (cfg_grpmod),
  .cfg_nsacc   (cfg_nsacc),
  .cfg_sec_dis (cfg_sec_dis),
  .sgi_hit     (sgi_hit),
  .set_ev      (set_ev),
  .pend_latch  (pend_latch),
  .pend_eff    (pend_eff),
  .pend_fire   (pend_fire)
);

// File: tb/prv_irq_pend_tb.sv
module prv_irq_pend_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ppi_line = '0;
  logic        sgi_valid = 1'b0;
  logic        sgi_ready;
  logic [3:0]  sgi_id = '0;
  logic [1:0]  sgi_grp = '0;
  logic        sgi_ns = 1'b0;
  logic [31:0] cfg_edge = '0, cfg_grp = '0, cfg_grpmod = '0, cfg_nsacc = '0;
  logic        cfg_sec_dis = 1'b0;
  logic [31:0] set_pend = '0, clr_pend = '0, irq_en = '0, irq_act = '0;
  logic [31:0] pend_eff, pend_fire;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  logic [31:0] m_latch = '0, m_fire = '0;
  logic [15:0] m_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prv_irq_pend u_dut (.*);

  function automatic logic [1:0] tgt_of(int n);
    if (cfg_grp[n]) return 2'd2;
    if (cfg_grpmod[n] && !cfg_sec_dis) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [31:0] sgi_vec();
    logic [1:0] t, r;
    logic [1:0] a;
    logic ok;
    if (!sgi_valid) return '0;
    t = tgt_of(int'(sgi_id));
    r = (sgi_grp == 2'd1 && t == 2'd0) ? 2'd0 : sgi_grp;
    ok = (r == t);
    a = cfg_nsacc[2*sgi_id +: 2];
    if (sgi_ns && !cfg_sec_dis) begin
      if (t == 2'd0 && a == 2'd0) ok = 1'b0;
      if (t == 2'd1 && a < 2'd2) ok = 1'b0;
    end
    return ok ? (32'd1 << sgi_id) : '0;
  endfunction

  function automatic logic [31:0] eff_now();
    return m_latch | ({m_lvl, 16'h0} & ~cfg_edge);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic [31:0] nl, nf, rise;
    rise = {ppi_line & ~m_lvl, 16'h0} & cfg_edge;
    nl = set_pend | rise | sgi_vec() | (m_latch & ~clr_pend);
    nf = eff_now() & irq_en & ~irq_act;
    @(posedge clk);
    m_latch = nl; m_lvl = ppi_line; m_fire = nf;
    @(negedge clk);
    chk(tag, pend_eff, eff_now(), "pend_eff");
    chk(tag, pend_fire, m_fire, "pend_fire");
    chk("R11", {31'd0, sgi_ready}, 32'd1, "sgi_ready");
  endtask

  task automatic sgi(logic [3:0] id, logic [1:0] g, logic ns);
    sgi_valid = 1'b1; sgi_id = id; sgi_grp = g; sgi_ns = ns;
    cyc();
    sgi_valid = 1'b0;
    clr_pend = 32'hFFFF;
    cyc();
    clr_pend = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", pend_eff, '0, "pend_eff in reset");
    chk("R1", pend_fire, '0, "pend_fire in reset");
    rst_n = 1'b1;
    cyc();
    irq_en = '1;

    tag = "R2"; cfg_edge = 32'h0008_0000;
    ppi_line[3] = 1'b1; cyc(); cyc();
    ppi_line[3] = 1'b0; cyc();
    chk("R2", pend_eff & 32'h0008_0000, 32'h0008_0000, "edge latch kept");

    tag = "R3"; ppi_line[5] = 1'b1; cyc();
    chk("R3", pend_eff & 32'h0020_0000, 32'h0020_0000, "level seen");
    ppi_line[5] = 1'b0; cyc();
    chk("R3", pend_eff & 32'h0020_0000, 32'h0, "level dropped");

    tag = "R4"; set_pend = 32'h20; cyc(); set_pend = '0; cyc();
    clr_pend = 32'h0008_0020; cyc(); clr_pend = '0; cyc();

    tag = "R5"; clr_pend = 32'h80; set_pend = 32'h80; cyc();
    set_pend = '0; cyc();
    ppi_line[3] = 1'b1; clr_pend = 32'h0008_0080; cyc(); clr_pend = '0; cyc();
    clr_pend = 32'h0008_0000; ppi_line[3] = 1'b0; cyc(); clr_pend = '0;
    clr_pend = 32'h4; sgi(4'd2, 2'd0, 1'b0);

    tag = "R6"; cfg_grpmod[2] = 1'b1;
    sgi(4'd2, 2'd1, 1'b0); sgi(4'd2, 2'd0, 1'b0);
    cfg_sec_dis = 1'b1; sgi(4'd2, 2'd0, 1'b0); sgi(4'd2, 2'd1, 1'b0);
    cfg_sec_dis = 1'b0; cfg_grpmod[2] = 1'b0;

    tag = "R7"; sgi(4'd2, 2'd1, 1'b0);

    tag = "R8"; cfg_grp[9] = 1'b1;
    sgi(4'd9, 2'd0, 1'b0); sgi(4'd9, 2'd3, 1'b0); sgi(4'd9, 2'd2, 1'b1);

    tag = "R9"; sgi(4'd4, 2'd0, 1'b1);
    cfg_nsacc[9:8] = 2'd1; sgi(4'd4, 2'd0, 1'b1);
    cfg_grpmod[4] = 1'b1; sgi(4'd4, 2'd1, 1'b1);
    cfg_nsacc[9:8] = 2'd2; sgi(4'd4, 2'd1, 1'b1);
    cfg_nsacc[9:8] = 2'd0; cfg_sec_dis = 1'b1; cfg_grpmod[4] = 1'b0;
    sgi(4'd4, 2'd0, 1'b1); cfg_sec_dis = 1'b0;

    tag = "R10"; set_pend = 32'h0000_0301; cyc(); set_pend = '0;
    irq_act = 32'h0000_0100; cyc(); irq_en = 32'hFFFF_FDFF; cyc(); cyc();
    irq_act = '0; irq_en = '1; clr_pend = '1; cyc(); clr_pend = '0; cyc();

    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) begin
        cfg_edge = $urandom; cfg_grp = $urandom; cfg_grpmod = $urandom;
        cfg_nsacc = $urandom; cfg_sec_dis = ($urandom % 4) == 0;
      end
      if (($urandom % 4) == 0) ppi_line = ppi_line ^ (16'd1 << ($urandom % 16));
      set_pend  = (($urandom % 8) == 0) ? (32'd1 << ($urandom % 32)) : '0;
      clr_pend  = (($urandom % 6) == 0) ? $urandom : '0;
      irq_en    = (($urandom % 16) == 0) ? $urandom : irq_en;
      irq_act   = (($urandom % 16) == 0) ? ($urandom & $urandom) : irq_act;
      sgi_valid = ($urandom % 3) == 0;
      sgi_id    = 4'($urandom);
      sgi_grp   = 2'($urandom);
      sgi_ns    = 1'($urandom);
      cyc();
    end
    sgi_valid = 1'b0; set_pend = '0; clr_pend = '0;
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule